// File: doc/BRIEF.md
# DMA Descriptor Chain Sequencer

This block is the control engine of a single DMA channel. Software fills a set of channel registers (device address, memory address, size word and link word) and picks a mode. In chained mode a start makes the engine read four-word descriptors from memory, beginning at the word address held in the link register. In single mode a start makes it run the one descriptor already in the registers.

For each descriptor the engine decodes the element width and the element count from the size word, checks them, and then issues one transfer request per element. Each request carries the fixed device address, the current memory address and the element size in bytes. The memory address moves forward by the element size after every acknowledged element. When the last element is done, the two low bits of the link word decide what happens next. The engine either fetches the next descriptor or stops with a completion pulse. It can also raise an interrupt pulse.

The data movement itself is handled elsewhere. This block only sequences the fetches and the element handshakes, and it reports its phase on a two-bit state output.

Top module: `dma_chain_seq`

## Requirements
- R1: While reset is high and in the cycle after it, state_o is 0 and mrd_req_o, xfer_req_o, done_o, irq_o and err_o are all low.
- R2: With mode_i = 1 (chained), a start in idle enters the descriptor-read state (code 1). It reads four words at byte addresses A, A+4, A+8 and A+12, where A is cfg_next_i with its two low bits cleared. The words are taken as device address, memory address, size and link, in that order. mrd_addr_o holds steady until mrd_ack_i.
- R3: With mode_i = 2 (single), a start in idle loads the four cfg_* inputs as the descriptor and goes straight to the wait state (code 2), with no memory read.
- R4: Size bits [13:12] select the element width (3 gives 1 byte, 2 gives 2 bytes, 0 gives 4 bytes), and bits [11:0] give the element count. Exactly that many transfer requests are acknowledged, and xfer_bytes_o shows the width in bytes.
- R5: Each acknowledged element advances xfer_mem_o by the element width. xfer_dev_o stays fixed for the whole descriptor.
- R6: Link bits [1:0] are the link code: bit 1 set means follow, bit 1 clear means last. After the last element of a last descriptor, the engine is idle with done_o high for one cycle. In chained mode a follow descriptor fetches the next one at the link word with bits [1:0] cleared.
- R7: After the last element of a descriptor whose link bit 0 is set, irq_o pulses for one cycle. This applies to both follow and last descriptors.
- R8: A descriptor is bad if its width code is 1, its count is 0, its count is above 0x3FF for 1- or 2-byte width or above 0x7FF for 4-byte width, or any of size bits [31:14] is set. A bad descriptor issues no transfers, and the engine returns to idle with done_o and err_o high together for one cycle.
- R9: state_o reads 0 idle, 1 descriptor read, 2 wait and 3 access. The wait state lasts exactly one cycle, between loading a descriptor and its first element.
- R10: A mode_i of 0 or 3 while the engine is busy returns it to idle on the next cycle, without done_o or irq_o.
- R11: A start while the engine is not idle is ignored. The run in progress continues with its own addresses.
- R12: In single mode the engine stops after the one descriptor even when its link code says follow, and it gives done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 0 off, 1 chained, 2 single, 3 off |
| start_i | input | 1 | Start request, taken only in idle |
| cfg_dev_i | input | 32 | Device address register |
| cfg_mem_i | input | 32 | Memory address register |
| cfg_size_i | input | 32 | Size register (width code and count) |
| cfg_next_i | input | 32 | Link register (address and link code) |
| mrd_req_o | output | 1 | Descriptor word read request |
| mrd_addr_o | output | 32 | Descriptor word byte address |
| mrd_ack_i | input | 1 | Read acknowledge, data valid |
| mrd_data_i | input | 32 | Read data |
| xfer_req_o | output | 1 | Element transfer request |
| xfer_dev_o | output | 32 | Device address of the element |
| xfer_mem_o | output | 32 | Memory address of the element |
| xfer_bytes_o | output | 3 | Element size in bytes (1, 2 or 4) |
| xfer_ack_i | input | 1 | Element transfer acknowledge |
| state_o | output | 2 | Engine state code |
| done_o | output | 1 | Completion pulse |
| irq_o | output | 1 | Interrupt pulse |
| err_o | output | 1 | Bad descriptor pulse, with done_o |

## Verification
The hardest situations to reach are a mode change or a second start that lands while the engine is part-way through a chain. That can be during a descriptor fetch, or in the middle of an element run behind acknowledges that arrive only some of the time. The stimulus watches state_o until it reads the fetch or access code, then drops the mode or pulses start in that exact cycle. A reference model, driven by the same irregular acknowledge pattern, predicts every output on every cycle. Boundary counts of 0x3FF and 0x7FF, the first illegal counts and a set reserved bit are each run in single mode.

// File: rtl/dcs_pkg.sv
`timescale 1ns/1ps
package dcs_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = 12;
    localparam int DESC_WORDS = 4;
    localparam int RSVD_W     = DATA_W - CNT_W - 2;

    localparam logic [CNT_W-1:0] MAX_NARROW = CNT_W'(12'h3FF);
    localparam logic [CNT_W-1:0] MAX_WIDE   = CNT_W'(12'h7FF);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DREAD = 2'd1,
        ST_WAIT  = 2'd2,
        ST_XFER  = 2'd3
    } state_e;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_CHAIN  = 2'd1,
        MODE_SINGLE = 2'd2,
        MODE_RSVD   = 2'd3
    } mode_e;

    typedef struct packed {
        logic [RSVD_W-1:0] rsvd;
        logic [1:0]        wcode;
        logic [CNT_W-1:0]  count;
    } size_t;

    typedef struct packed {
        logic [ADDR_W-3:0] addr;
        logic              follow;
        logic              irq;
    } link_t;

    typedef struct packed {
        logic [ADDR_W-1:0] dev;
        logic [ADDR_W-1:0] mem;
        size_t             size;
        link_t             link;
    } desc_t;

    function automatic logic [2:0] elem_bytes(input logic [1:0] wc);
        case (wc)
            2'd3:    return 3'd1;
            2'd2:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic size_bad(input size_t s);
        logic narrow;
        narrow = (s.wcode != 2'd0);
        return (s.wcode == 2'd1) || (s.count == '0) || (s.rsvd != '0) ||
               (narrow && (s.count > MAX_NARROW)) || (s.count > MAX_WIDE);
    endfunction
endpackage

// File: rtl/dcs_fetch.sv
`timescale 1ns/1ps
module dcs_fetch
    import dcs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NW = DESC_WORDS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_base_i,
    input  logic [AW-3:0]   base_i,
    input  logic            load_cfg_i,
    input  logic [NW*DW-1:0] cfg_i,
    input  logic            active_i,
    input  logic            ack_i,
    input  logic [DW-1:0]   data_i,
    output logic [AW-1:0]   addr_o,
    output logic            last_word_o,
    output logic [NW*DW-1:0] desc_o
);
    localparam int IW = (NW > 1) ? $clog2(NW) : 1;

    logic [AW-3:0] base_q;
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            idx_q  <= '0;
        end else if (load_base_i) begin
            base_q <= base_i;
            idx_q  <= '0;
        end else if (active_i && ack_i) begin
            idx_q <= (idx_q == IW'(NW - 1)) ? '0 : idx_q + 1'b1;
        end
    end

    assign addr_o      = {base_q + (AW-2)'(idx_q), 2'b00};
    assign last_word_o = (idx_q == IW'(NW - 1));

    for (genvar g = 0; g < NW; g++) begin : g_word
        logic [DW-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (load_cfg_i)
                word_q <= cfg_i[(NW-1-g)*DW +: DW];
            else if (active_i && ack_i && (idx_q == IW'(g)))
                word_q <= data_i;
        end
        assign desc_o[(NW-1-g)*DW +: DW] = word_q;
    end
endmodule

// File: rtl/dcs_elem.sv
`timescale 1ns/1ps
module dcs_elem
    import dcs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [AW-1:0] addr_i,
    input  logic [2:0]    step_i,
    input  logic          ack_i,
    output logic [AW-1:0] addr_o,
    output logic [2:0]    step_o,
    output logic          last_o
);
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] addr_q;
    logic [2:0]    step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            addr_q <= '0;
            step_q <= '0;
        end else if (load_i) begin
            cnt_q  <= cnt_i;
            addr_q <= addr_i;
            step_q <= step_i;
        end else if (ack_i) begin
            cnt_q  <= cnt_q - 1'b1;
            addr_q <= addr_q + AW'(step_q);
        end
    end

    assign addr_o = addr_q;
    assign step_o = step_q;
    assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/dma_chain_seq.sv
`timescale 1ns/1ps
module dma_chain_seq
    import dcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  mode_i,
    input  logic        start_i,
    input  logic [31:0] cfg_dev_i,
    input  logic [31:0] cfg_mem_i,
    input  logic [31:0] cfg_size_i,
    input  logic [31:0] cfg_next_i,
    output logic        mrd_req_o,
    output logic [31:0] mrd_addr_o,
    input  logic        mrd_ack_i,
    input  logic [31:0] mrd_data_i,
    output logic        xfer_req_o,
    output logic [31:0] xfer_dev_o,
    output logic [31:0] xfer_mem_o,
    output logic [2:0]  xfer_bytes_o,
    input  logic        xfer_ack_i,
    output logic [1:0]  state_o,
    output logic        done_o,
    output logic        irq_o,
    output logic        err_o
);
    state_e st_q;
    logic   single_q, done_q, irq_q, err_q;

    logic [DESC_WORDS*DATA_W-1:0] desc_flat;
    desc_t desc;
    assign desc = desc_t'(desc_flat);

    logic run_ok, go_chain, go_single, last_word, fetch_done;
    logic bad, elem_load, elem_ack, elem_last, desc_end, relink, load_base;
    logic [ADDR_W-3:0] base_sel;

    assign run_ok     = (mode_i == MODE_CHAIN) || (mode_i == MODE_SINGLE);
    assign go_chain   = (st_q == ST_IDLE) && start_i && (mode_i == MODE_CHAIN);
    assign go_single  = (st_q == ST_IDLE) && start_i && (mode_i == MODE_SINGLE);
    assign fetch_done = (st_q == ST_DREAD) && run_ok && mrd_ack_i && last_word;
    assign bad        = size_bad(desc.size);
    assign elem_load  = (st_q == ST_WAIT) && run_ok && !bad;
    assign elem_ack   = (st_q == ST_XFER) && run_ok && xfer_ack_i;
    assign desc_end   = elem_ack && elem_last;
    assign relink     = desc_end && desc.link.follow && !single_q;
    assign load_base  = go_chain || relink;
    assign base_sel   = go_chain ? cfg_next_i[ADDR_W-1:2] : desc.link.addr;

    dcs_fetch #(.AW(ADDR_W), .DW(DATA_W), .NW(DESC_WORDS)) i_fetch (
        .clk         (clk),
        .rst         (rst),
        .load_base_i (load_base),
        .base_i      (base_sel),
        .load_cfg_i  (go_single),
        .cfg_i       ({cfg_dev_i, cfg_mem_i, cfg_size_i, cfg_next_i}),
        .active_i    ((st_q == ST_DREAD) && run_ok),
        .ack_i       (mrd_ack_i),
        .data_i      (mrd_data_i),
        .addr_o      (mrd_addr_o),
        .last_word_o (last_word),
        .desc_o      (desc_flat)
    );

    dcs_elem #(.AW(ADDR_W), .CW(CNT_W)) i_elem (
        .clk    (clk),
        .rst    (rst),
        .load_i (elem_load),
        .cnt_i  (desc.size.count),
        .addr_i (desc.mem),
        .step_i (elem_bytes(desc.size.wcode)),
        .ack_i  (elem_ack),
        .addr_o (xfer_mem_o),
        .step_o (xfer_bytes_o),
        .last_o (elem_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            single_q <= 1'b0;
            done_q   <= 1'b0;
            irq_q    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            irq_q  <= 1'b0;
            err_q  <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (go_chain) begin
                        st_q     <= ST_DREAD;
                        single_q <= 1'b0;
                    end else if (go_single) begin
                        st_q     <= ST_WAIT;
                        single_q <= 1'b1;
                    end
                end
                ST_DREAD: begin
                    if (!run_ok)
                        st_q <= ST_IDLE;
                    else if (fetch_done)
                        st_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (!run_ok) begin
                        st_q <= ST_IDLE;
                    end else if (bad) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                    end else begin
                        st_q <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (!run_ok) begin
                        st_q <= ST_IDLE;
                    end else if (desc_end) begin
                        irq_q <= desc.link.irq;
                        if (relink) begin
                            st_q <= ST_DREAD;
                        end else begin
                            st_q   <= ST_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o    = st_q;
    assign mrd_req_o  = (st_q == ST_DREAD);
    assign xfer_req_o = (st_q == ST_XFER);
    assign xfer_dev_o = desc.dev;
    assign done_o     = done_q;
    assign irq_o      = irq_q;
    assign err_o      = err_q;
endmodule

// File: rtl/dcs_chk.sv
`timescale 1ns/1ps
module dcs_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  mode_i,
    input logic        mrd_ack_i,
    input logic [31:0] mrd_addr_o,
    input logic        xfer_ack_i,
    input logic        xfer_req_o,
    input logic [31:0] xfer_dev_o,
    input logic [31:0] xfer_mem_o,
    input logic [2:0]  xfer_bytes_o,
    input logic [1:0]  state_o,
    input logic        done_o,
    input logic        irq_o,
    input logic        err_o
);
    logic run_ok;
    assign run_ok = (mode_i == 2'd1) || (mode_i == 2'd2);

    // R2
    rd_addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd1 && $past(state_o) == 2'd1 && $past(mrd_ack_i) && $past(run_ok))
        |-> mrd_addr_o == $past(mrd_addr_o) + 32'd4);

    // R2
    rd_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd1 && $past(state_o) == 2'd1 && !$past(mrd_ack_i))
        |-> $stable(mrd_addr_o));

    // R4
    width_code_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_req_o |-> $countones(xfer_bytes_o) == 1);

    // R5
    mem_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd3 && $past(state_o) == 2'd3 && $past(xfer_ack_i) && $past(run_ok))
        |-> xfer_mem_o == $past(xfer_mem_o) + 32'($past(xfer_bytes_o)));

    // R5
    dev_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd3 && $past(state_o) == 2'd3) |-> $stable(xfer_dev_o));

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> state_o == 2'd0);

    // R7
    irq_after_access_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(state_o) == 2'd3);

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);

    // R8
    err_from_wait_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(state_o) == 2'd2);

    // R9
    wait_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state_o) == 2'd2 && $past(run_ok)) |-> state_o != 2'd2);

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o != 2'd0 && !run_ok) |=> (state_o == 2'd0 && !done_o && !irq_o));
endmodule

bind dma_chain_seq dcs_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (mode_i),
    .mrd_ack_i    (mrd_ack_i),
    .mrd_addr_o   (mrd_addr_o),
    .xfer_ack_i   (xfer_ack_i),
    .xfer_req_o   (xfer_req_o),
    .xfer_dev_o   (xfer_dev_o),
    .xfer_mem_o   (xfer_mem_o),
    .xfer_bytes_o (xfer_bytes_o),
    .state_o      (state_o),
    .done_o       (done_o),
    .irq_o        (irq_o),
    .err_o        (err_o)
);

// File: tb/test_dma_chain_seq.sv
`timescale 1ns/1ps
module test_dma_chain_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'd0;
    logic        start = 1'b0;
    logic [31:0] c_dev = '0, c_mem = '0, c_size = '0, c_next = '0;
    logic        mrd_req, mrd_ack = 1'b0;
    logic [31:0] mrd_addr, mrd_data = '0;
    logic        xreq, xack = 1'b0;
    logic [31:0] xdev, xmem;
    logic [2:0]  xbytes;
    logic [1:0]  state;
    logic        done, irq, err;

    always #4 clk = ~clk;

    dma_chain_seq i_dma_chain_seq (
        .clk(clk), .rst(rst), .mode_i(mode), .start_i(start),
        .cfg_dev_i(c_dev), .cfg_mem_i(c_mem), .cfg_size_i(c_size), .cfg_next_i(c_next),
        .mrd_req_o(mrd_req), .mrd_addr_o(mrd_addr), .mrd_ack_i(mrd_ack), .mrd_data_i(mrd_data),
        .xfer_req_o(xreq), .xfer_dev_o(xdev), .xfer_mem_o(xmem), .xfer_bytes_o(xbytes),
        .xfer_ack_i(xack), .state_o(state), .done_o(done), .irq_o(irq), .err_o(err)
    );

    logic [31:0] mem [int unsigned];
    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'd0;
    endfunction

    int n_cmp = 0, n_bad = 0;
    bit fin = 0;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int          ph = 0, widx = 0, mcnt = 0, mbytes = 0;
    logic [31:0] mbase = '0, mmem = '0;
    logic [31:0] mw [4];
    bit          msingle = 0, mdone = 0, mirq = 0, merr = 0;

    always @(posedge clk) begin : model
        int  wc, n;
        bit  ok;
        mdone = 0; mirq = 0; merr = 0;
        ok = (mode == 2'd1) || (mode == 2'd2);
        if (rst) begin
            ph = 0; widx = 0;
        end else begin
            case (ph)
                0: if (start && mode == 2'd1) begin
                       ph = 1; widx = 0; msingle = 0;
                       mbase = {c_next[31:2], 2'b00};
                   end else if (start && mode == 2'd2) begin
                       ph = 2; msingle = 1;
                       mw[0] = c_dev; mw[1] = c_mem; mw[2] = c_size; mw[3] = c_next;
                   end
                1: if (!ok) ph = 0;
                   else if (mrd_ack) begin
                       mw[widx] = mrd_data;
                       widx++;
                       if (widx == 4) begin widx = 0; ph = 2; end
                   end
                2: if (!ok) ph = 0;
                   else begin
                       wc = int'(mw[2][13:12]);
                       n  = int'(mw[2][11:0]);
                       if (wc == 1 || n == 0 || mw[2][31:14] != 0 || (wc != 0 && n > 1023) || n > 2047) begin
                           ph = 0; mdone = 1; merr = 1;
                       end else begin
                           ph = 3; mcnt = n; mmem = mw[1];
                           mbytes = (wc == 3) ? 1 : (wc == 2) ? 2 : 4;
                       end
                   end
                3: if (!ok) ph = 0;
                   else if (xack) begin
                       mmem = mmem + mbytes;
                       mcnt--;
                       if (mcnt == 0) begin
                           mirq = mw[3][0];
                           if (mw[3][1] && !msingle) begin
                               ph = 1; widx = 0; mbase = {mw[3][31:2], 2'b00};
                           end else begin
                               ph = 0; mdone = 1;
                           end
                       end
                   end
                default: ph = 0;
            endcase
        end
    end

    // Per-cycle comparison and responders
    int pat = 0, n_xacc = 0, n_done = 0, n_irq = 0, n_err = 0, n_mrd = 0;

    always @(negedge clk) begin
        if (!rst && !fin) begin
            check("R9", "state", {30'd0, state}, ph[31:0]);
            check("R2", "mrd_req", {31'd0, mrd_req}, {31'd0, ph == 1});
            if (ph == 1) check("R2", "mrd_addr", mrd_addr, mbase + 32'(4 * widx));
            check("R4", "xfer_req", {31'd0, xreq}, {31'd0, ph == 3});
            if (ph == 3) begin
                check("R4", "xfer_bytes", {29'd0, xbytes}, mbytes[31:0]);
                check("R5", "xfer_dev", xdev, mw[0]);
                check("R5", "xfer_mem", xmem, mmem);
            end
            check("R6", "done", {31'd0, done}, {31'd0, mdone});
            check("R7", "irq", {31'd0, irq}, {31'd0, mirq});
            check("R8", "err", {31'd0, err}, {31'd0, merr});
            n_done += int'(done); n_irq += int'(irq); n_err += int'(err);
        end
        pat++;
        mrd_ack  = !rst && mrd_req && (pat % 3 != 1);
        mrd_data = rd(mrd_addr);
        xack     = !rst && xreq && (pat % 4 != 2);
        if (xack) n_xacc++;
        if (mrd_ack) n_mrd++;
    end

    int s_x, s_d, s_i, s_e, s_m;
    task automatic snap();
        s_x = n_xacc; s_d = n_done; s_i = n_irq; s_e = n_err; s_m = n_mrd;
    endtask

    task automatic go(input logic [1:0] m);
        @(negedge clk); mode = m; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 6000; i++) begin
            if (state == 2'd0) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic run_single(input logic [31:0] sz, input logic [31:0] lk,
                              input int ex_x, input int ex_d, input int ex_i, input int ex_e, input string req);
        c_dev = 32'hB000_0040; c_mem = 32'h0004_0000; c_size = sz; c_next = lk;
        snap();
        go(2'd2);
        wait_idle();
        check(req, "single transfers", n_xacc - s_x, ex_x);
        check(req, "single done", n_done - s_d, ex_d);
        check(req, "single irq", n_irq - s_i, ex_i);
        check(req, "single err", n_err - s_e, ex_e);
        check("R3", "single reads", n_mrd - s_m, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(8 * 150000);
        if (!fin) begin
            fin = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        mem[32'h100] = 32'hA000_0010; mem[32'h104] = 32'h0001_0000;
        mem[32'h108] = 32'h0000_3003; mem[32'h10C] = 32'h0000_0203;
        mem[32'h200] = 32'hA000_0020; mem[32'h204] = 32'h0002_0000;
        mem[32'h208] = 32'h0000_2002; mem[32'h20C] = 32'h0000_0302;
        mem[32'h300] = 32'hA000_0030; mem[32'h304] = 32'h0003_0000;
        mem[32'h308] = 32'h0000_0004; mem[32'h30C] = 32'h0000_0001;
        mem[32'h600] = 32'hA000_0060; mem[32'h604] = 32'h0006_0000;
        mem[32'h608] = 32'h0000_1002; mem[32'h60C] = 32'h0000_0000;
        mem[32'h500] = 32'hDEAD_0000;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "state in reset", {30'd0, state}, 32'd0);
        check("R1", "requests in reset", {30'd0, mrd_req, xreq}, 32'd0);
        check("R1", "flags in reset", {29'd0, done, irq, err}, 32'd0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1", "state after reset", {30'd0, state}, 32'd0);

        // Three-descriptor chain, with an ignored start (R11)
        c_next = 32'h0000_0102;
        snap();
        go(2'd1);
        for (int i = 0; i < 200; i++) begin
            if (state == 2'd3) break;
            @(negedge clk);
        end
        c_next = 32'h0000_0500; start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R11", "state after busy start", {30'd0, state}, ph[31:0]);
        wait_idle();
        check("R4", "chain transfers", n_xacc - s_x, 9);
        check("R6", "chain done", n_done - s_d, 1);
        check("R7", "chain irq", n_irq - s_i, 2);
        check("R8", "chain err", n_err - s_e, 0);
        check("R11", "chain reads", n_mrd - s_m, 12);

        // Single mode
        run_single(32'h0000_0002, 32'h0000_0402, 2, 1, 0, 0, "R12");
        run_single(32'h0000_3001, 32'h0000_0001, 1, 1, 1, 0, "R7");
        run_single(32'h0000_23FF, 32'h0000_0000, 1023, 1, 0, 0, "R4");
        run_single(32'h0000_07FF, 32'h0000_0000, 2047, 1, 0, 0, "R4");
        // R8: bad descriptors
        run_single(32'h0000_1005, 32'h0000_0001, 0, 1, 0, 1, "R8");
        run_single(32'h0000_3000, 32'h0000_0000, 0, 1, 0, 1, "R8");
        run_single(32'h0000_3400, 32'h0000_0000, 0, 1, 0, 1, "R8");
        run_single(32'h0000_0800, 32'h0000_0000, 0, 1, 0, 1, "R8");
        run_single(32'h0001_0002, 32'h0000_0000, 0, 1, 0, 1, "R8");

        // Bad descriptor fetched in chained mode
        c_next = 32'h0000_0600;
        snap();
        go(2'd1);
        wait_idle();
        check("R8", "chain bad err", n_err - s_e, 1);
        check("R8", "chain bad transfers", n_xacc - s_x, 0);
        check("R2", "chain bad reads", n_mrd - s_m, 4);

        // R10: abort during access
        c_next = 32'h0000_0100;
        snap();
        go(2'd1);
        for (int i = 0; i < 200; i++) begin
            if (state == 2'd3) break;
            @(negedge clk);
        end
        mode = 2'd0;
        @(negedge clk);
        check("R10", "state after abort", {30'd0, state}, 32'd0);
        repeat (3) @(negedge clk);
        check("R10", "done after abort", n_done - s_d, 0);

        // R10: abort during descriptor read with mode 3
        snap();
        go(2'd1);
        check("R2", "state in fetch", {30'd0, state}, 32'd1);
        mode = 2'd3;
        @(negedge clk);
        check("R10", "state after fetch abort", {30'd0, state}, 32'd0);
        repeat (3) @(negedge clk);
        check("R10", "flags after fetch abort", n_done - s_d + n_irq - s_i, 0);

        fin = 1;
        summary();
        $finish;
    end
endmodule